// File: doc/BRIEF.md
# Threshold-Triggered Audio Sample FIFO

This block holds audio samples for one direction of a serial audio port, sitting between the bus-side data register and the serial shifter. One side pushes 32-bit words and the other side pops them. A parameter selects whether the instance serves transmit or receive. The choice decides how the DMA request is computed. For transmit the block asks for data while it has enough free entries. For receive it asks to be drained while it holds enough entries. The buffer is 32 words deep, which is room for two 16-word DMA bursts.

Software reaches the block through a six-bit control word. Bit 0 flushes the buffer and clears itself. Bit 1 gates the DMA request. Bits 5:2 hold the request threshold. A seven-bit status vector records overflow, underflow, request, full and drain events. Each status bit is cleared by writing a one to its position. A separate enable mask selects which status bits drive the single interrupt line.

Top module: `audio_tfifo`

## Requirements
- R1: After synchronous reset, the control word reads 0x20 (threshold 8, DMA off, flush bit 0). Status is 0, `irq` is 0, `dma_req` is 0, `level` is 0 and `pop_valid` is 0.
- R2: Popped words come out in the order they were pushed. `pop_data` and `pop_valid` are registered and appear on the clock edge that accepts the pop. `level` tracks the number of stored words.
- R3: Writing a 1 to control bit 0 empties the buffer on the following clock edge. A push that falls on that edge is discarded, and the bit reads back as 0 from then on.
- R4: In a transmit instance, `dma_req` is 1 exactly when control bit 1 is set and (32 - level) >= threshold. The output is registered one cycle after the level or control change.
- R5: In a receive instance, `dma_req` is 1 exactly when control bit 1 is set and level >= threshold, with the same one-cycle latency.
- R6: While control bit 1 is 0, `dma_req` stays 0 for every threshold and level.
- R7: A push while the buffer holds 32 words is dropped, even if a pop happens in the same cycle. It sets status bit 0 (overflow) and leaves the stored contents unchanged.
- R8: A pop from an empty buffer returns no data (`pop_valid` stays 0) and sets status bit 1 (underflow).
- R9: Status bit 2 is set while `dma_req` is 1. Bit 3 is set while the level is 32. Bit 4 is set when a pop takes the level from 1 to 0. Bits 6:5 always read 0.
- R10: Writing `sts_clr_mask` with `sts_clr_we` clears every status bit whose mask bit is 1. If a bit's event occurs in the same cycle, the set takes priority and the bit stays 1.
- R11: `irq` is a register that follows the OR over all bits of (status AND enable mask) one cycle later. The enable mask resets to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 6 | Control word: [5:2] threshold, [1] DMA enable, [0] flush |
| ctl_rdata | output | 6 | Control word readback |
| ien_we | input | 1 | Interrupt enable mask write strobe |
| ien_wdata | input | 7 | Interrupt enable mask value |
| sts_clr_we | input | 1 | Status clear strobe |
| sts_clr_mask | input | 7 | Ones clear the matching status bits |
| sts | output | 7 | Status vector |
| irq | output | 1 | Interrupt request |
| push | input | 1 | Write one word into the buffer |
| push_data | input | 32 | Word to write |
| pop | input | 1 | Read one word from the buffer |
| pop_data | output | 32 | Word read |
| pop_valid | output | 1 | `pop_data` holds a word from the last pop |
| level | output | 6 | Number of stored words |
| dma_req | output | 1 | DMA service request |

## Verification
The main same-cycle collision is between a status clear and a fresh event of the same bit. The bench fills the buffer, then drives an overflowing push together with a clear of bit 0. It expects the bit to read 1 afterwards, and to read 0 after a later clear alone. A second collision is a flush write followed by a push on the flush edge, which must leave the level at 0. The request logic is swept over all sixteen thresholds and every level from 0 to 32, with transmit and receive instances side by side. The expected request is computed arithmetically for each point.

// File: rtl/tfifo_pkg.sv
package tfifo_pkg;
  localparam int STS_W = 7;
  localparam int CTL_W = 6;

  localparam int ST_OVF   = 0;
  localparam int ST_UDF   = 1;
  localparam int ST_REQ   = 2;
  localparam int ST_FULL  = 3;
  localparam int ST_DRAIN = 4;

  typedef struct packed {
    logic [3:0] thresh;
    logic       dma_en;
    logic       flush;
  } ctl_t;
endpackage

// File: rtl/tfifo_ctrl.sv
module tfifo_ctrl
  import tfifo_pkg::*;
#(
  parameter int TH_RESET = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output ctl_t             ctl
);
  ctl_t ctl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q.thresh <= 4'(TH_RESET);
      ctl_q.dma_en <= 1'b0;
      ctl_q.flush  <= 1'b0;
    end else if (we) begin
      ctl_q <= ctl_t'(wdata);
    end else begin
      ctl_q.flush <= 1'b0;
    end
  end

  assign ctl = ctl_q;

  AST_FLUSH_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (ctl_q.flush && !we) |=> !ctl_q.flush); // R3
endmodule

// File: rtl/tfifo_store.sv
module tfifo_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic          pop_valid,
  output logic [CW-1:0] level,
  output logic          ovf_evt,
  output logic          udf_evt,
  output logic          drain_evt
);
  localparam logic [CW-1:0] FULLV = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] level_q;
  logic          full, empty, push_ok, pop_ok;

  assign full    = (level_q == FULLV);
  assign empty   = (level_q == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;

  assign ovf_evt   = push && full && !flush;
  assign udf_evt   = pop && empty && !flush;
  assign drain_evt = pop_ok && !push_ok && (level_q == CW'(1));

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (pop_ok) pop_data <= mem[rp_q];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp_q      <= '0;
      rp_q      <= '0;
      level_q   <= '0;
      pop_valid <= 1'b0;
    end else begin
      pop_valid <= pop_ok;
      if (push_ok) wp_q <= wp_q + 1'b1;
      if (pop_ok)  rp_q <= rp_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  assign level = level_q;

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    level_q <= FULLV); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !flush) |=> (level_q == FULLV)); // R7
  AST_NO_UNDERFLOW_DATA: assert property (@(posedge clk) disable iff (rst)
    (pop && empty) |=> !pop_valid); // R8
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> (level_q == '0)); // R3
endmodule

// File: rtl/tfifo_irq.sv
module tfifo_irq
  import tfifo_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [STS_W-1:0] set_evt,
  input  logic             clr_we,
  input  logic [STS_W-1:0] clr_mask,
  input  logic             en_we,
  input  logic [STS_W-1:0] en_wdata,
  output logic [STS_W-1:0] sts,
  output logic             irq
);
  logic [STS_W-1:0] sts_q, en_q, clr_v;

  assign clr_v = clr_we ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= '0;
      en_q  <= '0;
      irq   <= 1'b0;
    end else begin
      sts_q <= (sts_q & ~clr_v) | set_evt;
      if (en_we) en_q <= en_wdata;
      irq <= |(sts_q & en_q);
    end
  end

  assign sts = sts_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|set_evt) |=> ((sts_q & $past(set_evt)) == $past(set_evt))); // R10
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (!(|(sts_q & en_q))) |=> !irq); // R11
endmodule

// File: rtl/audio_tfifo.sv
module audio_tfifo
  import tfifo_pkg::*;
#(
  parameter int DW       = 32,
  parameter int DEPTH    = 32,
  parameter bit IS_TX    = 1'b1,
  parameter int TH_RESET = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ctl_we,
  input  logic [5:0]                 ctl_wdata,
  output logic [5:0]                 ctl_rdata,
  input  logic                       ien_we,
  input  logic [6:0]                 ien_wdata,
  input  logic                       sts_clr_we,
  input  logic [6:0]                 sts_clr_mask,
  output logic [6:0]                 sts,
  output logic                       irq,
  input  logic                       push,
  input  logic [DW-1:0]              push_data,
  input  logic                       pop,
  output logic [DW-1:0]              pop_data,
  output logic                       pop_valid,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       dma_req
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULLV = CW'(DEPTH);

  ctl_t             ctl;
  logic [CW-1:0]    lvl, metric;
  logic             ovf_evt, udf_evt, drain_evt;
  logic [STS_W-1:0] set_evt;

  tfifo_ctrl #(.TH_RESET(TH_RESET)) u_ctrl (
    .clk(clk), .rst(rst), .we(ctl_we), .wdata(ctl_wdata), .ctl(ctl)
  );

  tfifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .flush(ctl.flush),
    .push(push), .push_data(push_data), .pop(pop),
    .pop_data(pop_data), .pop_valid(pop_valid), .level(lvl),
    .ovf_evt(ovf_evt), .udf_evt(udf_evt), .drain_evt(drain_evt)
  );

  generate
    if (IS_TX) begin : g_tx
      assign metric = FULLV - lvl;
    end else begin : g_rx
      assign metric = lvl;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) dma_req <= 1'b0;
    else     dma_req <= ctl.dma_en && (metric >= CW'(ctl.thresh));
  end

  always_comb begin
    set_evt           = '0;
    set_evt[ST_OVF]   = ovf_evt;
    set_evt[ST_UDF]   = udf_evt;
    set_evt[ST_REQ]   = dma_req;
    set_evt[ST_FULL]  = (lvl == FULLV);
    set_evt[ST_DRAIN] = drain_evt;
  end

  tfifo_irq u_irq (
    .clk(clk), .rst(rst), .set_evt(set_evt),
    .clr_we(sts_clr_we), .clr_mask(sts_clr_mask),
    .en_we(ien_we), .en_wdata(ien_wdata), .sts(sts), .irq(irq)
  );

  assign ctl_rdata = ctl;
  assign level     = lvl;

  AST_REQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !ctl.dma_en |=> !dma_req); // R6
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    sts[6:5] == 2'b00); // R9
endmodule

// File: tb/audio_tfifo_test.sv
`timescale 1ns/1ps
module audio_tfifo_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_we = 0, ien_we = 0, sts_clr_we = 0, push = 0, pop = 0;
  logic [5:0]  ctl_wdata = '0;
  logic [6:0]  ien_wdata = '0, sts_clr_mask = '0;
  logic [31:0] push_data = '0;

  logic [5:0]  ctl_rdata, ctl_rdata_r;
  logic [6:0]  sts, sts_r;
  logic        irq, irq_r, pop_valid, pop_valid_r, dma_req, dma_req_r;
  logic [31:0] pop_data, pop_data_r;
  logic [5:0]  level, level_r;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  audio_tfifo #(.IS_TX(1'b1)) uut (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .ien_we(ien_we), .ien_wdata(ien_wdata), .sts_clr_we(sts_clr_we), .sts_clr_mask(sts_clr_mask),
    .sts(sts), .irq(irq), .push(push), .push_data(push_data), .pop(pop),
    .pop_data(pop_data), .pop_valid(pop_valid), .level(level), .dma_req(dma_req)
  );

  audio_tfifo #(.IS_TX(1'b0)) uut_rx (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata_r),
    .ien_we(ien_we), .ien_wdata(ien_wdata), .sts_clr_we(sts_clr_we), .sts_clr_mask(sts_clr_mask),
    .sts(sts_r), .irq(irq_r), .push(push), .push_data(push_data), .pop(pop),
    .pop_data(pop_data_r), .pop_valid(pop_valid_r), .level(level_r), .dma_req(dma_req_r)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [3:0] th, input logic en, input logic fl);
    ctl_we = 1; ctl_wdata = {th, en, fl};
    cyc(1);
    ctl_we = 0;
    cyc(3);
  endtask

  task automatic do_push(input logic [31:0] d);
    push = 1; push_data = d;
    cyc(1);
    push = 0;
    cyc(1);
  endtask

  task automatic clr_sts(input logic [6:0] m);
    sts_clr_we = 1; sts_clr_mask = m;
    cyc(1);
    sts_clr_we = 0;
    cyc(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 0;
    cyc(1);
    // R1 reset state
    chk("R1", "ctl", ctl_rdata, 6'h20);
    chk("R1", "sts", sts, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "dma_req", dma_req, 0);
    chk("R1", "level", level, 0);
    chk("R1", "pop_valid", pop_valid, 0);

    // R3 flush self-clear, push on flush edge dropped
    do_push(32'h11); do_push(32'h22); do_push(32'h33);
    chk("R2", "level after 3 pushes", level, 3);
    ctl_we = 1; ctl_wdata = {4'd8, 1'b0, 1'b1};
    cyc(1);
    ctl_we = 0;
    chk("R3", "flush bit set", ctl_rdata[0], 1);
    push = 1; push_data = 32'h44;
    cyc(1);
    push = 0;
    chk("R3", "flush readback", ctl_rdata, 6'h20);
    chk("R3", "level after flush", level, 0);
    cyc(1);
    chk("R3", "push on flush edge dropped", level, 0);

    // R6 request off with enable clear
    for (int th = 0; th < 16; th += 5) begin
      wr_ctl(4'(th), 1'b0, 1'b1);
      chk("R6", "tx req disabled", dma_req, 0);
      chk("R6", "rx req disabled", dma_req_r, 0);
    end

    // R4 R5 sweep thresholds and levels
    for (int th = 0; th < 16; th++) begin
      wr_ctl(4'(th), 1'b1, 1'b1);
      for (int lv = 0; lv <= 32; lv++) begin
        chk("R2", "sweep level", level, lv);
        chk("R4", "tx req", dma_req, ((32 - lv) >= th) ? 1 : 0);
        chk("R5", "rx req", dma_req_r, (lv >= th) ? 1 : 0);
        if (lv < 32) do_push(32'(th * 100 + lv));
      end
    end
    // R9 request bit seen while req high
    chk("R9", "req status bit", sts[2], 1);

    // R2 order
    wr_ctl(4'd8, 1'b0, 1'b1);
    for (int i = 0; i < 5; i++) do_push(32'hA000 + 32'(i * 7));
    for (int i = 0; i < 5; i++) begin
      pop = 1;
      cyc(1);
      pop = 0;
      chk("R2", "pop_valid", pop_valid, 1);
      chk("R2", "pop_data", pop_data, 32'hA000 + 32'(i * 7));
      cyc(1);
    end
    chk("R2", "level drained", level, 0);

    // R7 overflow
    clr_sts(7'h7F);
    chk("R10", "all cleared", sts, 0);
    for (int i = 0; i < 32; i++) do_push(32'(i * 3 + 1));
    chk("R9", "full status bit", sts[3], 1);
    chk("R7", "no ovf before extra push", sts[0], 0);
    push = 1; pop = 1; push_data = 32'hDEAD;
    cyc(1);
    push = 0; pop = 0;
    chk("R2", "pop at full", pop_data, 1);
    cyc(1);
    chk("R7", "overflow bit", sts[0], 1);
    chk("R7", "level after dropped push", level, 31);
    for (int i = 1; i < 32; i++) begin
      pop = 1;
      cyc(1);
      pop = 0;
      chk("R7", "contents unchanged", pop_data, 32'(i * 3 + 1));
      cyc(1);
    end
    chk("R7", "level empty", level, 0);
    chk("R9", "drain bit", sts[4], 1);
    chk("R9", "reserved bits", sts[6:5], 0);

    // R8 underflow
    pop = 1;
    cyc(1);
    pop = 0;
    chk("R8", "no pop_valid", pop_valid, 0);
    chk("R8", "underflow bit", sts[1], 1);
    cyc(1);

    // R10 same-cycle set and clear
    clr_sts(7'h7F);
    chk("R10", "cleared again", sts, 0);
    for (int i = 0; i < 32; i++) do_push(32'(i));
    push = 1; push_data = 32'hBEEF; sts_clr_we = 1; sts_clr_mask = 7'h01;
    cyc(1);
    push = 0; sts_clr_we = 0;
    cyc(1);
    chk("R10", "set wins over clear", sts[0], 1);
    clr_sts(7'h01);
    chk("R10", "clear alone", sts[0], 0);
    chk("R10", "other bit kept", sts[3], 1);

    // R11 interrupt masking
    ien_we = 1; ien_wdata = 7'h01;
    cyc(1);
    ien_we = 0;
    cyc(2);
    chk("R11", "masked full gives no irq", irq, 0);
    do_push(32'h5);
    cyc(1);
    chk("R11", "irq on overflow", irq, 1);
    clr_sts(7'h01);
    cyc(1);
    chk("R11", "irq dropped after clear", irq, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule